// File: doc/BRIEF.md
# Phase-Locked Differential Clock Pair Generator

This block divides one fast reference clock (64 MHz in the target system) into two low-frequency square waves. The first is a bit clock for the 2.5 to 5 kHz band. The second is a slower data-rate clock for the 150 to 300 Hz band. Each clock leaves the block as a complementary pair: a true output and its logical inverse. Both clocks come from one shared counter chain, so they never drift apart.

The slow clock changes state only on the same reference edge as a falling edge of the bit clock. Every slow-clock transition therefore comes half a bit period before the next bit-clock rising edge, so a downstream sampler has setup margin. Both division ratios are fixed when the block is elaborated. There is no data stream and no handshake: the enable and reset are plain control pins, and the four outputs are plain levels.

With the defaults (`HALF_CNT` = 8000, `SLOW_BITS` = 8) and a 64 MHz reference, the bit clock runs at 4 kHz and the slow clock at 250 Hz.

Top module: `clkpair_gen`

## Requirements
- R1: While `rst` is sampled high on a `clk_ref` edge, that edge sets `bclk_p` = 0, `bclk_n` = 1, `sclk_p` = 0 and `sclk_n` = 1.
- R2: The bit clock toggles once every `HALF_CNT` enabled reference cycles. Its period is 2×`HALF_CNT` enabled cycles at 50% duty. After reset is released, the first rising edge appears on the `HALF_CNT`-th enabled edge.
- R3: The slow clock toggles once every `SLOW_BITS` full bit-clock periods, so its half-period is 2×`HALF_CNT`×`SLOW_BITS` enabled cycles at 50% duty. After reset is released, its first rising edge falls on the enabled edge numbered 2×`HALF_CNT`×`SLOW_BITS`.
- R4: After the first edge, `bclk_n` is always the inverse of `bclk_p`, and `sclk_n` is always the inverse of `sclk_p`. Both members of a pair change on the same reference edge.
- R5: A slow-clock transition happens only on the same reference edge as a bit-clock falling edge. It therefore precedes the next bit-clock rising edge by `HALF_CNT` enabled cycles.
- R6: An edge with `en` low and `rst` low changes no output and advances no counter. When `en` returns high, the waveform continues exactly where it stopped.
- R7: A reset applied in the middle of a run restarts both clocks from the R1 state, and the timing of R2 and R3 applies again from the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock that feeds the whole counter chain |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; while low, all counters and outputs hold |
| bclk_p | output | 1 | Bit clock, true output |
| bclk_n | output | 1 | Bit clock, inverted output |
| sclk_p | output | 1 | Slow clock, true output |
| sclk_n | output | 1 | Slow clock, inverted output |

## Verification
The prescaler count is hidden state. If it is wrong, the next bit-clock edge moves, and the error shows within one bit half-period, at most `HALF_CNT` enabled cycles. The falling-edge counter in the slow divider is also hidden, and an error there shows only at the next slow transition. That transition either arrives too early or too late, or lands away from a bit-clock falling edge, and it can take up to a full slow half-period to appear. A pair register that loses its complement shows on the very next reference edge, as both pins at the same level. The bench compares all four pins on every edge against a closed-form model, so hold-under-enable, mid-run reset and phase faults are all caught.

// File: rtl/clkpair_pkg.sv
package clkpair_pkg;
  localparam int unsigned NUM_PAIRS = 2;
  localparam int unsigned PAIR_BIT  = 0;
  localparam int unsigned PAIR_SLOW = 1;
  typedef logic [NUM_PAIRS-1:0] pair_vec_t;
endpackage

// File: rtl/clkpair_prescaler.sv
module clkpair_prescaler #(
  parameter int unsigned HALF_CNT = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CNT - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else if (en)   cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R2
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/clkpair_slowdiv.sv
module clkpair_slowdiv #(
  parameter int unsigned SLOW_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fall_tick,
  output logic flip
);
  localparam int unsigned SW = (SLOW_BITS > 1) ? $clog2(SLOW_BITS) : 1;
  localparam logic [SW-1:0] LAST = SW'(SLOW_BITS - 1);

  logic [SW-1:0] fcnt_q;

  assign flip = fall_tick && (fcnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)            fcnt_q <= '0;
    else if (flip)      fcnt_q <= '0;
    else if (fall_tick) fcnt_q <= fcnt_q + 1'b1;
  end

  AST_SLOWCNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    fcnt_q <= LAST); // R3
  AST_SLOWCNT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !fall_tick |=> $stable(fcnt_q)); // R5
endmodule

// File: rtl/clkpair_outreg.sv
module clkpair_outreg (
  input  logic clk,
  input  logic rst,
  input  logic toggle,
  output logic p,
  output logic n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      p <= 1'b0;
      n <= 1'b1;
    end else if (toggle) begin
      p <= ~p;
      n <= p;
    end
  end

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    p != n); // R4
  AST_PAIR_RESET: assert property (@(posedge clk)
    rst |=> (!p && n)); // R1
endmodule

// File: rtl/clkpair_gen.sv
module clkpair_gen #(
  parameter int unsigned HALF_CNT  = 8000,
  parameter int unsigned SLOW_BITS = 8
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic en,
  output logic bclk_p,
  output logic bclk_n,
  output logic sclk_p,
  output logic sclk_n
);
  import clkpair_pkg::*;

  logic      bit_tick;
  logic      fall_tick;
  logic      slow_flip;
  pair_vec_t tog;
  pair_vec_t pv;
  pair_vec_t nv;

  clkpair_prescaler #(.HALF_CNT(HALF_CNT)) u_pre (
    .clk (clk_ref),
    .rst (rst),
    .en  (en),
    .tick(bit_tick)
  );

  assign fall_tick = bit_tick && pv[PAIR_BIT];

  clkpair_slowdiv #(.SLOW_BITS(SLOW_BITS)) u_slow (
    .clk      (clk_ref),
    .rst      (rst),
    .fall_tick(fall_tick),
    .flip     (slow_flip)
  );

  assign tog[PAIR_BIT]  = bit_tick;
  assign tog[PAIR_SLOW] = slow_flip;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    clkpair_outreg u_out (
      .clk   (clk_ref),
      .rst   (rst),
      .toggle(tog[g]),
      .p     (pv[g]),
      .n     (nv[g])
    );
  end

  assign bclk_p = pv[PAIR_BIT];
  assign bclk_n = nv[PAIR_BIT];
  assign sclk_p = pv[PAIR_SLOW];
  assign sclk_n = nv[PAIR_SLOW];

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_ref) disable iff (rst)
    !en |=> ($stable(bclk_p) && $stable(sclk_p))); // R6
  AST_SLOW_ON_BIT_FALL: assert property (@(posedge clk_ref) disable iff (rst)
    !$stable(sclk_p) |-> $fell(bclk_p)); // R5
  AST_BIT_EDGE_NEEDS_EN: assert property (@(posedge clk_ref) disable iff (rst)
    !$stable(bclk_p) |-> $past(en)); // R2
endmodule

// File: tb/tb_clkpair_gen.sv
module tb_clkpair_gen;
  localparam int unsigned H = 3;
  localparam int unsigned S = 4;

  typedef struct packed {
    logic       rst;
    logic       en;
    logic [3:0] exp; // {bclk_p, bclk_n, sclk_p, sclk_n}
  } item_t;

  logic clk_ref = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic bclk_p, bclk_n, sclk_p, sclk_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  item_t q[$];
  int unsigned k = 0;

  always #4 clk_ref = ~clk_ref;

  clkpair_gen #(.HALF_CNT(H), .SLOW_BITS(S)) dut (
    .clk_ref(clk_ref), .rst(rst), .en(en),
    .bclk_p(bclk_p), .bclk_n(bclk_n), .sclk_p(sclk_p), .sclk_n(sclk_n)
  );

  function automatic logic [3:0] model(input int unsigned kk);
    logic b, s;
    b = ((kk / H) % 2) == 1;
    s = ((kk / (2 * H * S)) % 2) == 1;
    return {b, ~b, s, ~s};
  endfunction

  task automatic drive(input logic r, input logic e);
    item_t it;
    @(negedge clk_ref);
    rst = r;
    en = e;
    if (r) k = 0;
    else if (e) k = k + 1;
    it.rst = r;
    it.en = e;
    it.exp = model(k);
    q.push_back(it);
  endtask

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic [3:0] prev;
    bit have_prev;
    have_prev = 1'b0;
    prev = '0;
    forever begin
      @(posedge clk_ref);
      #2;
      if (q.size() != 0) begin
        item_t it;
        logic [3:0] act;
        it = q.pop_front();
        act = {bclk_p, bclk_n, sclk_p, sclk_n};
        if (it.rst) begin
          check(act == 4'b0101, "R1", act, 4'b0101);
          check(act == it.exp, "R7", act, it.exp);
        end else begin
          check(act[3:2] == it.exp[3:2], "R2", act, it.exp);
          check(act[1:0] == it.exp[1:0], "R3", act, it.exp);
          check((act[3] != act[2]) && (act[1] != act[0]), "R4", act, it.exp);
          if (!it.en && have_prev)
            check(act == prev, "R6", act, prev);
          if (have_prev && (act[1] != prev[1]))
            check(prev[3] && !act[3], "R5", act, it.exp);
        end
        prev = act;
        have_prev = 1'b1;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_ref);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // driver
  initial begin
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0);       // R1 reset state
    for (int i = 0; i < 250; i++) drive(1'b0, 1'b1);     // R2 R3 R5 free run
    for (int i = 0; i < 200; i++) drive(1'b0, (i % 3) != 0); // R6 gapped enable
    for (int i = 0; i < 20; i++) drive(1'b0, 1'b0);      // R6 long hold
    for (int i = 0; i < 37; i++) drive(1'b0, 1'b1);
    for (int i = 0; i < 2; i++) drive(1'b1, 1'b1);       // R7 mid-run reset
    for (int i = 0; i < 150; i++) drive(1'b0, 1'b1);     // R7 restart timing
    for (int i = 0; i < 60; i++) drive(1'b0, (i % 5) < 2);
    @(negedge clk_ref);
    @(negedge clk_ref);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule